// File: doc/BRIEF.md
# Toggle-Handshake Command Word Crossing

This block moves a multi-bit command word from a source clock domain into an unrelated destination clock domain. The source side registers the input every cycle. An input that differs from the value seen on the cycle before, that is not the idle code, and that arrives while the block is not busy is taken as a new command. The block then holds the word and flips a single toggle bit. Only that toggle bit is synchronized into the destination domain.

In the destination domain, a chain of flip-flops of configurable depth re-times the toggle. One more register plus an XOR turns each toggle edge into a single-cycle pulse. On that pulse, the held word is loaded into the output register and a strobe is raised for one destination cycle. On every other cycle the output shows the programmable idle code.

The re-timed toggle is also sent back to the source through a second chain of the same depth. The source-side busy flag stays high until that returned level matches the local toggle. The source therefore knows when the word has been delivered and the next command may be issued.

Top module: `cmd_cross`

## Requirements
- R1: After reset, `cmd_out` equals the `IDLE` parameter value, `cmd_strobe` is 0 and `busy` is 0.
- R2: `cmd_in` is accepted as a command on a source clock edge when all three of these hold: it differs from the value sampled on the previous source edge, it differs from `IDLE`, and `busy` is 0. On the next source edge after acceptance, `busy` reads 1.
- R3: Every accepted command appears on `cmd_out` exactly once, with its exact value, marked by `cmd_strobe`. This holds whether the source clock is faster or slower than the destination clock.
- R4: `cmd_strobe` is high for exactly one destination cycle per command. Whenever `cmd_strobe` is 0, `cmd_out` equals `IDLE`.
- R5: An input equal to `IDLE` is never accepted. It leaves `busy` at 0 and produces no strobe.
- R6: Input changes while `busy` is 1 are dropped. The held word does not change. A value that is still present when `busy` falls is not taken, because it equals the previously sampled value.
- R7: Holding the same non-idle value on `cmd_in` for many cycles produces only one command.
- R8: `busy` falls only after the destination has issued the strobe for the pending command. It is driven by the return of the destination toggle level through a synchronizer of `SYNC_STAGES` flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| cmd_in | input | WIDTH | Command word, source domain |
| busy | output | 1 | Crossing in progress, source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low |
| cmd_out | output | WIDTH | Delivered command, `IDLE` when no strobe |
| cmd_strobe | output | 1 | One-cycle marker of a delivered command |

## Verification
A held word that is corrupted shows up as a wrong value on `cmd_out`. This appears within the forward synchronizer latency plus two destination cycles of the command being taken. A toggle or edge-detector fault shows up as a strobe that is missing or doubled against the scoreboard. A broken return path shows as `busy` that never falls, and the watchdog catches this. A broken comparator shows as a command taken for a repeated or idle input, which produces a strobe with no queued entry. Both clock orderings are run, so latency faults that depend on the clock ratio are exposed.

// File: rtl/cmd_cross.sv
module cmd_cross #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] IDLE = '0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             src_clk,
  input  logic             src_rst_n,
  input  logic [WIDTH-1:0] cmd_in,
  output logic             busy,
  input  logic             dst_clk,
  input  logic             dst_rst_n,
  output logic [WIDTH-1:0] cmd_out,
  output logic             cmd_strobe
);

  localparam int LAST = SYNC_STAGES - 1;

  initial begin
    if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
  end

  // source domain
  logic [WIDTH-1:0] prev_q, hold_q;
  logic             src_tgl;
  logic [LAST:0]    ack_sync;
  logic             take;

  assign busy = src_tgl ^ ack_sync[LAST];
  assign take = (cmd_in != prev_q) && (cmd_in != IDLE) && !busy;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      prev_q  <= IDLE;
      hold_q  <= IDLE;
      src_tgl <= 1'b0;
    end else begin
      prev_q <= cmd_in;
      if (take) begin
        hold_q  <= cmd_in;
        src_tgl <= ~src_tgl;
      end
    end
  end

  // destination domain
  logic [LAST:0] fwd_sync;
  logic          dst_dly;
  logic          edge_hit;

  assign edge_hit = fwd_sync[LAST] ^ dst_dly;

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      fwd_sync   <= '0;
      dst_dly    <= 1'b0;
      cmd_out    <= IDLE;
      cmd_strobe <= 1'b0;
    end else begin
      fwd_sync   <= {fwd_sync[LAST-1:0], src_tgl};
      dst_dly    <= fwd_sync[LAST];
      cmd_out    <= edge_hit ? hold_q : IDLE;
      cmd_strobe <= edge_hit;
    end
  end

  // return path to source
  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) ack_sync <= '0;
    else            ack_sync <= {ack_sync[LAST-1:0], dst_dly};
  end

  assert_busy_after_take_R2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    take |=> busy);
  assert_hold_stable_R6: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    busy |=> $stable(hold_q));
  assert_idle_ignored_R5: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (cmd_in == IDLE) |=> $stable(src_tgl));
  assert_strobe_single_R4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    cmd_strobe |=> !cmd_strobe);
  assert_idle_when_quiet_R4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !cmd_strobe |-> (cmd_out == IDLE));

endmodule

// File: tb/cmd_cross_test.sv
`timescale 1ns/1ps
module cmd_cross_test;
  localparam int W = 8;
  localparam logic [W-1:0] IDL = 8'h5A;

  logic src_clk = 0, dst_clk = 0, src_rst_n = 0, dst_rst_n = 0;
  logic [W-1:0] cmd_in = IDL;
  logic busy, cmd_strobe;
  logic [W-1:0] cmd_out;
  realtime dst_half = 6.5;

  cmd_cross #(.WIDTH(W), .IDLE(IDL), .SYNC_STAGES(3)) uut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .cmd_in(cmd_in), .busy(busy),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .cmd_out(cmd_out), .cmd_strobe(cmd_strobe));

  always #4 src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;

  int checks = 0, fails = 0;
  logic [W-1:0] q[$];
  logic prev_strobe = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge dst_clk) if (src_rst_n && dst_rst_n) begin
    if (cmd_strobe) begin
      if (q.size() == 0) chk(0, "R3 unexpected strobe", cmd_out, IDL);
      else begin
        logic [W-1:0] e;
        e = q.pop_front();
        chk(cmd_out == e, "R3", cmd_out, e);
      end
      if (prev_strobe) chk(0, "R4 strobe longer than one cycle", 1, 0);
    end else begin
      if (prev_strobe) chk(cmd_out == IDL, "R4 back to idle", cmd_out, IDL);
      else if (cmd_out != IDL) chk(0, "R4 idle value", cmd_out, IDL);
    end
    prev_strobe = cmd_strobe;
  end

  task automatic wait_idle();
    while (busy) @(negedge src_clk);
    repeat (2) @(negedge dst_clk);
    @(negedge src_clk);
  endtask

  task automatic send(logic [W-1:0] v, bit accept, string req);
    wait_idle();
    cmd_in = v;
    if (accept) q.push_back(v);
    @(negedge src_clk);
    chk(busy == accept, req, busy, accept);
    wait_idle();
    chk(q.size() == 0, "R8 delivered before busy fell", q.size(), 0);
  endtask

  task automatic run_phase();
    send(8'h11, 1, "R2");
    send(8'h11, 0, "R7");
    repeat (10) @(negedge src_clk);
    chk(busy == 0, "R7 held value", busy, 0);
    send(IDL, 0, "R5");
    send(8'hA3, 1, "R2");
    send(8'h00, 1, "R2");
    send(8'hFF, 1, "R2");
    // change while busy
    wait_idle();
    cmd_in = 8'h3C; q.push_back(8'h3C);
    @(negedge src_clk);
    chk(busy == 1, "R2", busy, 1);
    cmd_in = 8'hC3;
    wait_idle();
    repeat (6) @(negedge src_clk);
    chk(busy == 0, "R6 dropped change", busy, 0);
    chk(q.size() == 0, "R6 single delivery", q.size(), 0);
    for (int i = 0; i < 6; i++) send(W'(8'h20 + i*7), 1, "R3");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge src_clk);
    chk(cmd_out == IDL, "R1 cmd_out", cmd_out, IDL);
    chk(cmd_strobe == 0, "R1 strobe", cmd_strobe, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    src_rst_n = 1; dst_rst_n = 1;
    run_phase();        // source faster
    wait_idle();
    dst_half = 2.7;     // destination faster
    repeat (4) @(negedge dst_clk);
    cmd_in = IDL;
    run_phase();
    repeat (10) @(negedge dst_clk);
    chk(q.size() == 0, "R3 queue drained", q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule